// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block is a register-mapped timer peripheral. It has four independent channels, each a 32-bit down-counter with its own prescaler, and a shared interrupt section. Each channel can count over 16 or 32 bits. In one-shot mode it stops at zero. In periodic mode it reloads from a background value. In free-running mode it wraps to all ones.

Software reaches the block through a simple word-addressed port. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `addr` in the same cycle. Each channel raises a raw status bit when its count arrives at zero. A mask selects which raw bits drive the single interrupt output. Writing ones to the clear register removes raw status bits.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Word map:
  - Offset 0 is the mask (read/write, one bit per channel).
  - Offset 1 is raw status and offset 2 is masked status.
  - Offset 3 is the clear register; it is write-only and reads 0.
  - Channel n starts at offset 4+4n with four registers:
    - +0 is the load register; a read returns the background value.
    - +1 is the current count; it is read-only.
    - +2 is the control register.
    - +3 is the background reload value.
  - Offsets 20 and above read 0.
- R3: A load write sets both the count and the background value at that edge. A background write changes only the background value and leaves the count as it is.
- R4: Control bit 7 set: the count decreases by one on each prescaled tick. Bit 7 clear: the count holds.
- R5: Control bits 3:2 set the prescaler:
  - 00 gives a tick on every enabled cycle.
  - 01 gives a tick on every 16th enabled cycle.
  - 10 and 11 give a tick on every 256th enabled cycle.
  - The phase restarts on a load write.
- R6: Control bit 1 set selects 32-bit counting. Bit 1 clear selects 16-bit counting: the count reads only its low 16 bits, with the upper bits zero, and it wraps to 0xFFFF.
- R7: Control bit 0 set (one-shot): the count stays at zero once it gets there, until it is loaded again.
- R8: Bit 0 clear and control bit 6 set (periodic): the tick after zero reloads the count from the background value.
- R9: Bits 0 and 6 both clear (free-running): the tick after zero wraps the count to all ones for the selected width.
- R10: A tick that takes a count from 1 to 0 sets raw status bit n for that channel. A load write in the same cycle takes priority and sets nothing.
- R11: Writing the clear register:
  - Each 1 clears the matching raw bit.
  - A 0 leaves its bit unchanged.
  - A zero arrival in the same cycle leaves its bit set.
- R12: Masked status is raw status ANDed with the mask. `irq` is the OR of the masked bits.
- R13: Control readback returns only bits 7, 6, 3, 2, 1 and 0. All other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 5 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | OR of masked status bits |

## Verification
A clear-register write and a channel arriving at zero can land on the same edge. In that case the new event must survive the clear. The bench runs a periodic channel and counts edges so that a clear write hits the exact edge of its second zero arrival. It then reads raw status and expects the bit still set. One cycle later it issues a lone clear and expects that clear to take effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W       = 32;
    localparam int NARROW_W    = 16;
    localparam int PRE_W       = 8;
    localparam int SHARED_REGS = 4;
    localparam int REGS_PER_CH = 4;

    localparam int OFS_MASK   = 0;
    localparam int OFS_RAW    = 1;
    localparam int OFS_MSKD   = 2;
    localparam int OFS_CLR    = 3;
    localparam int CH_LOAD    = 0;
    localparam int CH_CUR     = 1;
    localparam int CH_CTRL    = 2;
    localparam int CH_BG      = 3;

    typedef enum logic [1:0] {
        PS_DIV1    = 2'b00,
        PS_DIV16   = 2'b01,
        PS_DIV256  = 2'b10,
        PS_DIV256R = 2'b11
    } presc_e;

    typedef struct packed {
        logic   enable;
        logic   periodic;
        presc_e presc;
        logic   wide;
        logic   oneshot;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CNT_W-1:0] w);
        ctrl_t c;
        c.enable   = w[7];
        c.periodic = w[6];
        c.presc    = presc_e'(w[3:2]);
        c.wide     = w[1];
        c.oneshot  = w[0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CNT_W-1:0] w;
        w    = '0;
        w[7] = c.enable;
        w[6] = c.periodic;
        w[3:2] = c.presc;
        w[1] = c.wide;
        w[0] = c.oneshot;
        return w;
    endfunction

    function automatic logic [PRE_W-1:0] presc_limit(input presc_e p);
        case (p)
            PS_DIV1:  return PRE_W'(0);
            PS_DIV16: return PRE_W'(15);
            default:  return PRE_W'(255);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] width_mask(input logic wide);
        return wide ? {CNT_W{1'b1}} : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   restart,
    input  presc_e presc,
    output logic   tick
);
    logic [PRE_W-1:0] pcnt_q;

    assign tick = run && !restart && (pcnt_q >= presc_limit(presc));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic             ctrl_we,
    input  logic             bg_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cur_val,
    output logic [CNT_W-1:0] bg_val,
    output ctrl_t            ctrl_val,
    output logic             zero_evt
);
    logic [CNT_W-1:0] cur_q, bg_q, wmask, cur_nxt;
    ctrl_t            ctrl_q;
    logic             tick;

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.enable),
        .restart (ld_we),
        .presc   (ctrl_q.presc),
        .tick    (tick)
    );

    assign wmask   = width_mask(ctrl_q.wide);
    assign cur_val = cur_q & wmask;

    always_comb begin
        if (cur_val == '0) begin
            if (ctrl_q.oneshot)       cur_nxt = '0;
            else if (ctrl_q.periodic) cur_nxt = bg_q & wmask;
            else                      cur_nxt = wmask;
        end else begin
            cur_nxt = cur_val - 1'b1;
        end
    end

    assign zero_evt = tick && !ld_we && (cur_val == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            bg_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (ld_we) begin
                cur_q <= wdata;
                bg_q  <= wdata;
            end else begin
                if (bg_we) bg_q  <= wdata;
                if (tick)  cur_q <= cur_nxt;
            end
            if (ctrl_we) ctrl_q <= ctrl_unpack(wdata);
        end
    end

    assign bg_val   = bg_q;
    assign ctrl_val = ctrl_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mask_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] evt,
    output logic [NCH-1:0] raw_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] masked,
    output logic           irq
);
    logic [NCH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;
    assign masked   = raw_q & mask_q;
    assign irq      = |masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            if (mask_we) mask_q <= wbits;
            raw_q <= (raw_q & ~clr_bits) | evt;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(SHARED_REGS + REGS_PER_CH * NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    logic [NCH-1:0][CNT_W-1:0] cnt_val, bg_val;
    ctrl_t [NCH-1:0]           ch_ctrl;
    logic [NCH-1:0]            ld_we, ctrl_we, bg_we, zero_evt;
    logic [NCH-1:0]            ch_en, ch_oneshot;
    logic [NCH-1:0]            raw_q, mask_q, masked;
    logic                      mask_we, clr_we;

    assign mask_we = wr_en && (addr == ADDR_W'(OFS_MASK));
    assign clr_we  = wr_en && (addr == ADDR_W'(OFS_CLR));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int BASE = SHARED_REGS + REGS_PER_CH * i;
        assign ld_we[i]   = wr_en && (addr == ADDR_W'(BASE + CH_LOAD));
        assign ctrl_we[i] = wr_en && (addr == ADDR_W'(BASE + CH_CTRL));
        assign bg_we[i]   = wr_en && (addr == ADDR_W'(BASE + CH_BG));
        assign ch_en[i]      = ch_ctrl[i].enable;
        assign ch_oneshot[i] = ch_ctrl[i].oneshot;

        tmr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .ld_we    (ld_we[i]),
            .ctrl_we  (ctrl_we[i]),
            .bg_we    (bg_we[i]),
            .wdata    (wdata),
            .cur_val  (cnt_val[i]),
            .bg_val   (bg_val[i]),
            .ctrl_val (ch_ctrl[i]),
            .zero_evt (zero_evt[i])
        );
    end

    tmr_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wbits   (wdata[NCH-1:0]),
        .evt     (zero_evt),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .masked  (masked),
        .irq     (irq)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_MASK)) rdata = CNT_W'(mask_q);
        if (addr == ADDR_W'(OFS_RAW))  rdata = CNT_W'(raw_q);
        if (addr == ADDR_W'(OFS_MSKD)) rdata = CNT_W'(masked);
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(SHARED_REGS + REGS_PER_CH * i + CH_LOAD)) rdata = bg_val[i];
            if (addr == ADDR_W'(SHARED_REGS + REGS_PER_CH * i + CH_CUR))  rdata = cnt_val[i];
            if (addr == ADDR_W'(SHARED_REGS + REGS_PER_CH * i + CH_CTRL)) rdata = ctrl_pack(ch_ctrl[i]);
            if (addr == ADDR_W'(SHARED_REGS + REGS_PER_CH * i + CH_BG))   rdata = bg_val[i];
        end
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [31:0]           wdata,
    input logic [31:0]           rdata,
    input logic                  irq,
    input logic [NCH-1:0][31:0]  cnt_val,
    input logic [NCH-1:0]        ch_en,
    input logic [NCH-1:0]        ch_oneshot,
    input logic [NCH-1:0]        zero_evt,
    input logic [NCH-1:0]        ld_we,
    input logic [NCH-1:0]        raw_q,
    input logic [NCH-1:0]        mask_q
);
    localparam int MAP_END = 4 + 4 * NCH;

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (32'(addr) >= MAP_END) |-> (rdata == '0));

    p_irq_needs_mask_r12: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    p_irq_needs_raw_r12: assert property (@(posedge clk) disable iff (rst)
        (raw_q == '0) |-> !irq);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_set_on_zero_r10: assert property (@(posedge clk) disable iff (rst)
            zero_evt[i] |=> raw_q[i]);

        p_clear_r11: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(3) && wdata[i] && !zero_evt[i]) |=> !raw_q[i]);

        p_hold_disabled_r4: assert property (@(posedge clk) disable iff (rst)
            (!ch_en[i] && !wr_en) |=> $stable(cnt_val[i]));

        p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && ch_oneshot[i] && cnt_val[i] == '0 && !wr_en) |=> (cnt_val[i] == '0));

        p_load_no_event_r10: assert property (@(posedge clk) disable iff (rst)
            ld_we[i] |-> !zero_evt[i]);
    end
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nfail = 0;

    tmr_unit dut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #4 clk = ~clk;

    function automatic logic [4:0] cha(input int n, input int off);
        return 5'(4 + 4 * n + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        rchk("R1 mask", 5'd0, 32'h0);
        rchk("R1 raw", 5'd1, 32'h0);
        rchk("R1 masked", 5'd2, 32'h0);
        @(negedge clk);
        rchk("R1 cur ch0", cha(0, 1), 32'h0);
        rchk("R1 ctrl ch3", cha(3, 2), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_count_and_hold();
        do_reset();
        wr(cha(0, 0), 32'd100);
        rchk("R3 load sets count", cha(0, 1), 32'd100);
        wr(cha(0, 2), 32'h82);
        repeat (10) @(negedge clk);
        rchk("R4 decrement", cha(0, 1), 32'd90);
        wr(cha(0, 2), 32'h02);
        rchk("R4 last tick", cha(0, 1), 32'd89);
        repeat (5) @(negedge clk);
        rchk("R4 disabled holds", cha(0, 1), 32'd89);
    endtask

    task automatic t_prescale();
        do_reset();
        wr(cha(1, 0), 32'd1000);
        wr(cha(1, 2), 32'h86);
        repeat (15) @(negedge clk);
        rchk("R5 div16 before", cha(1, 1), 32'd1000);
        @(negedge clk);
        rchk("R5 div16 tick", cha(1, 1), 32'd999);
        repeat (16) @(negedge clk);
        rchk("R5 div16 second", cha(1, 1), 32'd998);
        wr(cha(2, 0), 32'd500);
        wr(cha(3, 0), 32'd500);
        wr(cha(2, 2), 32'h8A);
        wr(cha(3, 2), 32'h8E);
        repeat (254) @(negedge clk);
        rchk("R5 div256 before", cha(2, 1), 32'd500);
        rchk("R5 reserved before", cha(3, 1), 32'd500);
        @(negedge clk);
        rchk("R5 div256 tick", cha(2, 1), 32'd499);
        @(negedge clk);
        rchk("R5 reserved tick", cha(3, 1), 32'd499);
    endtask

    task automatic t_oneshot_irq();
        do_reset();
        wr(5'd0, 32'h1);
        rchk("R2 mask readback", 5'd0, 32'h1);
        wr(cha(0, 0), 32'd5);
        wr(cha(0, 2), 32'h83);
        repeat (4) @(negedge clk);
        rchk("R7 count one", cha(0, 1), 32'd1);
        rchk("R10 raw not yet", 5'd1, 32'h0);
        @(negedge clk);
        rchk("R7 reach zero", cha(0, 1), 32'd0);
        rchk("R10 raw set", 5'd1, 32'h1);
        chk("R12 irq on", 32'(irq), 32'h1);
        rchk("R12 masked", 5'd2, 32'h1);
        repeat (10) @(negedge clk);
        rchk("R7 stays zero", cha(0, 1), 32'd0);
        wr(5'd3, 32'h0);
        rchk("R11 zero write no effect", 5'd1, 32'h1);
        wr(5'd0, 32'h0);
        chk("R12 irq masked off", 32'(irq), 32'h0);
        rchk("R12 masked off", 5'd2, 32'h0);
        wr(5'd3, 32'h1);
        rchk("R11 clear", 5'd1, 32'h0);
    endtask

    task automatic t_periodic();
        do_reset();
        wr(cha(2, 0), 32'd3);
        wr(cha(2, 3), 32'd7);
        rchk("R3 bg write keeps count", cha(2, 1), 32'd3);
        rchk("R3 bg value", cha(2, 3), 32'd7);
        rchk("R2 load offset reads bg", cha(2, 0), 32'd7);
        wr(cha(2, 2), 32'hC2);
        repeat (3) @(negedge clk);
        rchk("R8 at zero", cha(2, 1), 32'd0);
        @(negedge clk);
        rchk("R8 reload", cha(2, 1), 32'd7);
        @(negedge clk);
        rchk("R8 after reload", cha(2, 1), 32'd6);
    endtask

    task automatic t_freerun();
        do_reset();
        wr(cha(1, 0), 32'h1234_0002);
        rchk("R6 narrow read", cha(1, 1), 32'h0000_0002);
        wr(cha(1, 2), 32'h80);
        repeat (2) @(negedge clk);
        rchk("R6 narrow zero", cha(1, 1), 32'h0);
        rchk("R10 raw ch1", 5'd1, 32'h2);
        @(negedge clk);
        rchk("R9 narrow wrap", cha(1, 1), 32'h0000_FFFF);
        wr(cha(2, 0), 32'd1);
        wr(cha(2, 2), 32'h82);
        @(negedge clk);
        rchk("R9 wide zero", cha(2, 1), 32'h0);
        @(negedge clk);
        rchk("R9 wide wrap", cha(2, 1), 32'hFFFF_FFFF);
    endtask

    task automatic t_clear_collision();
        do_reset();
        wr(cha(3, 0), 32'd4);
        wr(cha(3, 2), 32'hC2);
        repeat (4) @(negedge clk);
        rchk("R10 first event", 5'd1, 32'h8);
        repeat (4) @(negedge clk);
        wr(5'd3, 32'h8);
        rchk("R11 set wins over clear", 5'd1, 32'h8);
        wr(5'd3, 32'h8);
        rchk("R11 lone clear", 5'd1, 32'h0);
    endtask

    task automatic t_map();
        do_reset();
        wr(cha(1, 2), 32'hFFFF_FFFF);
        rchk("R13 ctrl readback", cha(1, 2), 32'h0000_00CF);
        rchk("R2 clear reads zero", 5'd3, 32'h0);
        rchk("R2 unmapped 20", 5'd20, 32'h0);
        @(negedge clk);
        rchk("R2 unmapped 31", 5'd31, 32'h0);
        wr(cha(0, 1), 32'd55);
        rchk("R2 current is read-only", cha(0, 1), 32'h0);
    endtask

    initial begin
        #(200000 * 8);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_count_and_hold();
        t_prescale();
        t_oneshot_irq();
        t_periodic();
        t_freerun();
        t_clear_collision();
        t_map();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule